// File: doc/BRIEF.md
# Legacy Shadow Segment Router

This block steers host memory cycles in the upper part of the first megabyte (C0000h to FFFFFh) to one of two targets: main memory (DRAM) or the PCI bus. The window is cut into thirteen segments. Twelve segments are 16 KB each and cover C0000h to EFFFFh. One segment is 64 KB and covers F0000h to FFFFFh. Each segment holds a two-bit attribute with a separate read enable and write enable.

A read and a write to the same address can therefore be routed to different targets. This lets firmware copy a ROM image into DRAM: reads still come from PCI while writes go to DRAM, and once the copy is done reads are switched to DRAM.

Attributes are loaded through a simple configuration port, one segment per clock. Each decoded cycle produces a registered one-hot target select and an in-range flag one clock after it is presented. A disabled segment is never redirected to some other DRAM location; its cycles simply go to PCI.

Top module: `shadow_router`

## Requirements
- R1: After reset, the outputs `sel_dram`, `sel_pci` and `in_range` are low, and every segment attribute is disabled (value 00), so every in-window cycle is routed to PCI.
- R2: A valid cycle whose address lies outside 000C0000h to 000FFFFFh (any of bits [31:20] set, or bits [19:18] not both 1) gives `in_range`=0, `sel_dram`=0 and `sel_pci`=0 on the following clock.
- R3: A valid cycle inside the window gives `in_range`=1 on the following clock, with exactly one of `sel_dram` and `sel_pci` high.
- R4: A read (`cyc_write`=0) goes to DRAM if and only if bit 0 (read enable) of its segment attribute is 1; otherwise it goes to PCI.
- R5: A write (`cyc_write`=1) goes to DRAM if and only if bit 1 (write enable) of its segment attribute is 1; otherwise it goes to PCI.
- R6: For addresses C0000h to EFFFFh, the segment number is address bits [17:14] (0 to 11). Each segment is programmed through `cfg_idx` with the same number and is independent of the others.
- R7: Every address from F0000h to FFFFFh uses the single segment 12, whatever its offset.
- R8: An attribute written at a clock edge applies to cycles sampled from the next edge onward. A cycle sampled at the same edge as the write still uses the old value.
- R9: A configuration write with `cfg_idx` of 13, 14 or 15 changes no segment attribute.
- R10: When `cyc_valid` is low, all three outputs are low on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A host memory cycle is presented |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| cyc_addr | input | 32 | Byte address of the cycle |
| cfg_we | input | 1 | Load an attribute this clock |
| cfg_idx | input | 4 | Segment number to load (0 to 12) |
| cfg_attr | input | 2 | New attribute: bit 0 read enable, bit 1 write enable |
| sel_dram | output | 1 | Registered: cycle routed to main memory |
| sel_pci | output | 1 | Registered: cycle routed to PCI |
| in_range | output | 1 | Registered: cycle fell inside C0000h to FFFFFh |

## Verification
The properties assume that `cyc_write` and `cyc_addr` are stable and meaningful whenever `cyc_valid` is high. They also assume that the configuration port may be driven in the same clock as a decoded cycle, with that cycle seeing the attribute held before the write.

The stimulus changes every input only on the falling edge, which keeps these assumptions. Random addresses are weighted toward the window, and random configuration writes include the unused indices 13 to 15. Directed cases cover the segment edges at C0000h, DFFFFh, E0000h, EFFFFh, F0000h and FFFFFh, the first addresses outside the window, and a same-edge write followed by a cycle.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int ADDR_W    = 32;
    localparam int SEG_SHIFT = 14;
    localparam int N_LOW     = 8;
    localparam int N_EXT     = 4;
    localparam int N_SMALL   = N_LOW + N_EXT;
    localparam int N_SEG     = N_SMALL + 1;
    localparam int IDX_W     = $clog2(N_SEG);
    localparam int WIN_LSB   = 18;
    localparam int MB_LSB    = 20;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } seg_attr_t;

    typedef struct packed {
        logic in_range;
        logic to_dram;
        logic to_pci;
    } route_t;
endpackage

// File: rtl/seg_index.sv
module seg_index
    import shadow_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IDX_W
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] BIOS_IDX = IW'(N_SEG - 1);
    localparam logic [IW-1:0] SMALL_LIM = IW'(N_SMALL);

    logic [IW-1:0] raw_idx;

    always_comb begin
        hit     = (addr[AW-1:MB_LSB] == '0) && (&addr[MB_LSB-1:WIN_LSB]);
        raw_idx = addr[SEG_SHIFT+IW-1:SEG_SHIFT];
        if (raw_idx >= SMALL_LIM) begin
            idx = BIOS_IDX;
        end else begin
            idx = raw_idx;
        end
    end
endmodule

// File: rtl/attr_store.sv
module attr_store
    import shadow_pkg::*;
#(
    parameter int NS = N_SEG,
    parameter int IW = IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_idx,
    input  seg_attr_t       cfg_attr,
    input  logic [IW-1:0]   rd_idx,
    output seg_attr_t       rd_attr
);
    seg_attr_t attr_q [NS];
    seg_attr_t attr_d [NS];
    logic [NS-1:0] wsel;

    for (genvar g = 0; g < NS; g++) begin : g_sel
        assign wsel[g] = cfg_we && (cfg_idx == IW'(g));
    end

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            attr_d[i] = wsel[i] ? cfg_attr : attr_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NS; i++) begin
            if (!rst_n) attr_q[i] <= '0;
            else        attr_q[i] <= attr_d[i];
        end
    end

    always_comb begin
        rd_attr = '0;
        for (int i = 0; i < NS; i++) begin
            if (rd_idx == IW'(i)) rd_attr = attr_q[i];
        end
    end

    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wsel));
    p_bad_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx >= IW'(NS)) |-> (wsel == '0));
endmodule

// File: rtl/route_unit.sv
module route_unit
    import shadow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  logic      write,
    input  logic      hit,
    input  seg_attr_t attr,
    output route_t    route_q
);
    route_t route_d;
    logic   enable;

    always_comb begin
        route_d = '0;
        enable  = write ? attr.wr_en : attr.rd_en;
        if (valid && hit) begin
            route_d.in_range = 1'b1;
            route_d.to_dram  = enable;
            route_d.to_pci   = !enable;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({route_q.to_dram, route_q.to_pci})
        && (route_q.in_range == (route_q.to_dram || route_q.to_pci)));
    p_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !hit) |=> (route_q == '0));
    p_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && hit && !write) |=> (route_q.to_dram == $past(attr.rd_en)));
    p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && hit && write) |=> (route_q.to_dram == $past(attr.wr_en)));
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (route_q == '0));
endmodule

// File: rtl/shadow_router.sv
module shadow_router
    import shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_attr,
    output logic              sel_dram,
    output logic              sel_pci,
    output logic              in_range
);
    logic             hit;
    logic [IDX_W-1:0] seg;
    seg_attr_t        seg_attr;
    seg_attr_t        new_attr;
    route_t           route_q;

    assign new_attr = seg_attr_t'(cfg_attr);

    seg_index u_index (
        .addr (cyc_addr),
        .hit  (hit),
        .idx  (seg)
    );

    attr_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_attr (new_attr),
        .rd_idx   (seg),
        .rd_attr  (seg_attr)
    );

    route_unit u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cyc_valid),
        .write   (cyc_write),
        .hit     (hit),
        .attr    (seg_attr),
        .route_q (route_q)
    );

    assign sel_dram = route_q.to_dram;
    assign sel_pci  = route_q.to_pci;
    assign in_range = route_q.in_range;

    p_bios_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (&cyc_addr[17:16])) |-> (seg == IDX_W'(N_SEG - 1)));
endmodule

// File: tb/shadow_router_test.sv
module shadow_router_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cyc_valid = 0, cyc_write = 0, cfg_we = 0;
    logic [31:0] cyc_addr = '0;
    logic [3:0]  cfg_idx = '0;
    logic [1:0]  cfg_attr = '0;
    logic        sel_dram, sel_pci, in_range;
    logic [1:0]  model [13];
    int          n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    shadow_router uut (.*);

    function automatic int seg_of(logic [31:0] a);
        if (a[31:20] != 0 || a[19:18] != 2'b11) return -1;
        if (a[17:16] == 2'b11) return 12;
        return int'(a[17:14]);
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {in,dram,pci} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] expect_of(logic v, logic w, logic [31:0] a);
        int s = seg_of(a);
        logic en;
        if (!v || s < 0) return 3'b000;
        en = w ? model[s][1] : model[s][0];
        return en ? 3'b110 : 3'b101;
    endfunction

    // drive one clock of stimulus, then compare at the next falling edge
    task automatic step(string req, logic v, logic w, logic [31:0] a,
                        logic cw, logic [3:0] ci, logic [1:0] ca);
        logic [2:0] e;
        cyc_valid = v; cyc_write = w; cyc_addr = a;
        cfg_we = cw; cfg_idx = ci; cfg_attr = ca;
        e = expect_of(v, w, a);        // old attributes apply (R8)
        @(posedge clk);
        if (cw && ci < 13) model[ci] = ca;
        @(negedge clk);
        cfg_we = 0;
        check(req, {in_range, sel_dram, sel_pci}, e);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 13; i++) model[i] = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {in_range, sel_dram, sel_pci}, 3'b000);
        rst_n = 1;
        // R1: everything disabled, reads and writes to PCI
        step("R1 F0000 read", 1, 0, 32'h000F_0000, 0, 0, 0);
        step("R1 C0000 write", 1, 1, 32'h000C_0000, 0, 0, 0);
        // R2 boundaries
        step("R2 below window", 1, 0, 32'h000B_FFFF, 0, 0, 0);
        step("R2 above 1MB", 1, 0, 32'h0010_0000, 0, 0, 0);
        step("R2 alias high bit", 1, 0, 32'h800F_0000, 0, 0, 0);
        // R10 idle
        step("R10 idle", 0, 0, 32'h000F_0000, 0, 0, 0);
        // R6 independence: seg 7 read-only, neighbours stay disabled
        step("R6 cfg", 0, 0, 0, 1, 4'd7, 2'b01);
        step("R6 seg7 end read", 1, 0, 32'h000D_FFFF, 0, 0, 0);
        step("R6 seg8 read", 1, 0, 32'h000E_0000, 0, 0, 0);
        step("R5 seg7 write", 1, 1, 32'h000D_C000, 0, 0, 0);
        // R5 write-only on seg 11
        step("R5 cfg", 0, 0, 0, 1, 4'd11, 2'b10);
        step("R5 seg11 write", 1, 1, 32'h000E_FFFF, 0, 0, 0);
        step("R4 seg11 read", 1, 0, 32'h000E_C000, 0, 0, 0);
        // R7 shadow seg 12 read/write, any offset
        step("R7 cfg", 0, 0, 0, 1, 4'd12, 2'b11);
        step("R7 F0000", 1, 0, 32'h000F_0000, 0, 0, 0);
        step("R7 FFFFF", 1, 1, 32'h000F_FFFF, 0, 0, 0);
        step("R7 F8123", 1, 0, 32'h000F_8123, 0, 0, 0);
        // R8 same-edge write: cycle sees old (rw), next cycle sees new (off)
        step("R8 same edge", 1, 0, 32'h000F_4000, 1, 4'd12, 2'b00);
        step("R8 next edge", 1, 0, 32'h000F_4000, 0, 0, 0);
        // R9 unused indices leave segment 12 and 0 unchanged
        step("R9 idx13", 0, 0, 0, 1, 4'd13, 2'b11);
        step("R9 idx15", 0, 0, 0, 1, 4'd15, 2'b11);
        step("R9 seg12 read", 1, 0, 32'h000F_0000, 0, 0, 0);
        step("R9 seg0 write", 1, 1, 32'h000C_0000, 0, 0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = ($urandom % 4 != 0) ? (32'h000C_0000 | ($urandom & 32'h3_FFFF)) : $urandom;
            step("R3 R4 R5 random", ($urandom % 8) != 0, $urandom % 2, a,
                 ($urandom % 3) == 0, 4'($urandom), 2'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule